// File: doc/BRIEF.md
# Multi-Channel DMA Transfer Sequencer

This block chooses which of several DMA channels owns the bus and steps the bus through idle, read and write cycles for it. A channel asks for service with a one-clock request pulse. The block keeps that request until the channel is served. A channel can start only when its transfer-enable level and its stored master-enable bit are both 1. A single pair is one read cycle followed at once by one write cycle, and nothing can split the pair.

A non-burst channel runs one pair for each request. A burst channel, once selected, runs pairs back to back until one of three things happens: its loaded transfer count runs out, its master enable drops, or an external bus requester claims the bus after a write. A claimed burst resumes when the bus comes back. An external requester is granted the bus in idle cycles. A lower-priority secondary transfer engine is granted only in idle cycles that neither the external requester nor a DMA channel claims. A non-maskable interrupt input clears the master enable of every channel that is in burst mode, which stops any burst after the pair in progress. Non-burst channels ignore it.

Top module: `dma_xfer_seq`

## Requirements
- R1: Reset clears all held requests, master enables and burst state, and the block leaves reset idle with no grant. A request pulse seen during reset is not kept.
- R2: `cyc_o` is one-hot: bit 0 means idle, bit 1 means read and bit 2 means write. Every read cycle is followed in the next clock by a write cycle for the same channel, and a write is only ever entered from a read.
- R3: A channel starts a transfer only when its `xfer_en_i` bit is 1 and its master enable is 1. Until then its pending request is held.
- R4: Transfers of different channels, and separate non-burst transfers, are always separated by at least one idle cycle. A non-burst channel performs exactly one read/write pair per request.
- R5: Among the eligible channels, the lowest index wins. A request that loses stays pending and is served later. `act_ch_o` gives the binary index of the channel in read and write cycles.
- R6: `ext_gnt_o` is 1 exactly in idle cycles with `ext_req_i` at 1. While it is 1, no DMA transfer starts. After a write, a high `ext_req_i` forces the next cycle to idle, even in the middle of a burst. A burst cut short this way resumes once the request drops.
- R7: `sec_gnt_o` is 1 only in idle cycles in which `sec_req_i` is 1, `ext_req_i` is 0 and no DMA channel is eligible to start.
- R8: A pulse on `me_set_i[i]` sets master enable `i` and loads its count from `cnt_init_i`. A burst channel runs pairs with no idle cycle between them, each pair lowering the count by one, and ends after the pair that brings the count to zero. A burst channel whose count is zero does not start.
- R9: While `nmi_i` is 1, the master enable of every channel with `burst_i` at 1 is cleared, and this clear wins over a set in the same cycle. A pair already under way still completes, and then the bus goes idle. Master enables of non-burst channels are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_CH | Request pulse per channel |
| xfer_en_i | input | NUM_CH | Transfer-enable level per channel |
| me_set_i | input | NUM_CH | Pulse to set a master enable and load its count |
| burst_i | input | NUM_CH | Burst-mode flag per channel |
| cnt_init_i | input | CNT_W | Count loaded by `me_set_i` |
| nmi_i | input | 1 | Non-maskable interrupt level |
| ext_req_i | input | 1 | External bus request |
| sec_req_i | input | 1 | Secondary engine bus request |
| cyc_o | output | 3 | One-hot cycle indicator: idle, read, write |
| act_ch_o | output | $clog2(NUM_CH) | Channel in the current read or write |
| ext_gnt_o | output | 1 | Bus grant to the external requester |
| sec_gnt_o | output | 1 | Bus grant to the secondary engine |
| me_o | output | NUM_CH | Current master-enable bits |

## Verification
The assertions check on every cycle the properties that hold locally:
- the one-hot cycle code;
- the read-to-write pairing on one channel;
- that a channel can change only across an idle cycle;
- that grants appear only in idle cycles;
- that idle is forced after a write while the external request is high;
- that a started channel had both enables set;
- that the interrupt clears the master enables of burst channels.

Only the bench scenarios can show the properties that depend on history:
- the order in which held requests are served;
- the exact length of a burst against its loaded count;
- a preempted burst resuming to its full count;
- a zero-count burst staying parked;
- non-burst channels keeping their enable through an interrupt.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } seq_st_e;

   localparam int CYC_IDLE_BIT  = 0;
   localparam int CYC_READ_BIT  = 1;
   localparam int CYC_WRITE_BIT = 2;
endpackage

// File: rtl/dma_req_hold.sv
module dma_req_hold #(
   parameter int NUM_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req_i,
   input  logic [NUM_CH-1:0] clr_i,
   output logic [NUM_CH-1:0] pend_o
);
   for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
      logic held_q;
      always_ff @(posedge clk) begin
         if (!rst_n)         held_q <= 1'b0;
         else if (req_i[g])  held_q <= 1'b1;
         else if (clr_i[g])  held_q <= 1'b0;
      end
      assign pend_o[g] = held_q;
   end
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] me_set_i,
   input  logic [CNT_W-1:0]  cnt_init_i,
   input  logic              nmi_i,
   input  logic [NUM_CH-1:0] burst_i,
   input  logic [NUM_CH-1:0] dec_i,
   output logic [NUM_CH-1:0] me_nx_o,
   output logic [NUM_CH-1:0] me_q_o,
   output logic [NUM_CH-1:0] cnt_nz_o,
   output logic [NUM_CH-1:0] cnt_gt1_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic             me_q;
      logic [CNT_W-1:0] cnt_q;
      logic             me_nx;

      assign me_nx = (me_q | me_set_i[g]) & ~(nmi_i & burst_i[g]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            me_q  <= 1'b0;
            cnt_q <= '0;
         end else begin
            me_q <= me_nx;
            if (me_set_i[g])
               cnt_q <= cnt_init_i;
            else if (dec_i[g] && cnt_q != '0)
               cnt_q <= cnt_q - ONE;
         end
      end

      assign me_nx_o[g]   = me_nx;
      assign me_q_o[g]    = me_q;
      assign cnt_nz_o[g]  = (cnt_q != '0);
      assign cnt_gt1_o[g] = (cnt_q > ONE);
   end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
   parameter int NUM_CH = 3,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] elig_i,
   output logic [NUM_CH-1:0] oh_o,
   output logic [CH_W-1:0]   idx_o,
   output logic              any_o
);
   always_comb begin
      oh_o  = '0;
      idx_o = '0;
      any_o = 1'b0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (elig_i[i]) begin
            oh_o     = '0;
            oh_o[i]  = 1'b1;
            idx_o    = CH_W'(i);
            any_o    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
   import dma_seq_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 8,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req_i,
   input  logic [NUM_CH-1:0] xfer_en_i,
   input  logic [NUM_CH-1:0] me_set_i,
   input  logic [NUM_CH-1:0] burst_i,
   input  logic [CNT_W-1:0]  cnt_init_i,
   input  logic              nmi_i,
   input  logic              ext_req_i,
   input  logic              sec_req_i,
   output logic [2:0]        cyc_o,
   output logic [CH_W-1:0]   act_ch_o,
   output logic              ext_gnt_o,
   output logic              sec_gnt_o,
   output logic [NUM_CH-1:0] me_o
);
   if (NUM_CH < 2)  begin : g_bad_ch  $error("NUM_CH must be at least 2");  end
   if (NUM_CH > 16) begin : g_big_ch  $error("NUM_CH must not exceed 16"); end
   if (CNT_W < 1)   begin : g_bad_cnt $error("CNT_W must be at least 1");   end

   seq_st_e           st_q, st_d;
   logic [CH_W-1:0]   act_q;
   logic [NUM_CH-1:0] bact_q;
   logic [NUM_CH-1:0] pend, me_nx, me_q, cnt_nz, cnt_gt1;
   logic [NUM_CH-1:0] elig, pick_oh, clr, dec, act_oh;
   logic [CH_W-1:0]   pick_idx;
   logic              pick_any, start, cont, stop_b;

   dma_req_hold #(.NUM_CH(NUM_CH)) u_hold (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr), .pend_o(pend)
   );

   dma_chan_ctl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .me_set_i(me_set_i), .cnt_init_i(cnt_init_i),
      .nmi_i(nmi_i), .burst_i(burst_i), .dec_i(dec),
      .me_nx_o(me_nx), .me_q_o(me_q), .cnt_nz_o(cnt_nz), .cnt_gt1_o(cnt_gt1)
   );

   assign elig = (pend | bact_q) & xfer_en_i & me_nx & (~burst_i | cnt_nz);

   dma_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
      .elig_i(elig), .oh_o(pick_oh), .idx_o(pick_idx), .any_o(pick_any)
   );

   always_comb begin
      act_oh = '0;
      act_oh[act_q] = 1'b1;
      start  = (st_q == ST_IDLE) && pick_any && !ext_req_i;
      clr    = start ? pick_oh : '0;
      dec    = (st_q == ST_WRITE) ? (burst_i & act_oh) : '0;
      cont   = (st_q == ST_WRITE) && burst_i[act_q] && bact_q[act_q]
               && cnt_gt1[act_q] && me_nx[act_q] && xfer_en_i[act_q] && !ext_req_i;
      stop_b = (st_q == ST_WRITE) && !cont
               && (!cnt_gt1[act_q] || !me_nx[act_q] || !xfer_en_i[act_q]);
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (start) st_d = ST_READ;
         ST_READ:  st_d = ST_WRITE;
         ST_WRITE: st_d = cont ? ST_READ : ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         act_q <= '0;
      end else begin
         st_q <= st_d;
         if (start) act_q <= pick_idx;
      end
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_burst
      always_ff @(posedge clk) begin
         if (!rst_n)
            bact_q[g] <= 1'b0;
         else if (start && pick_oh[g])
            bact_q[g] <= burst_i[g];
         else if (stop_b && act_oh[g])
            bact_q[g] <= 1'b0;
         else
            bact_q[g] <= bact_q[g] & me_nx[g];
      end
   end

   always_comb begin
      cyc_o = '0;
      cyc_o[CYC_IDLE_BIT]  = (st_q == ST_IDLE);
      cyc_o[CYC_READ_BIT]  = (st_q == ST_READ);
      cyc_o[CYC_WRITE_BIT] = (st_q == ST_WRITE);
   end

   assign act_ch_o  = act_q;
   assign ext_gnt_o = (st_q == ST_IDLE) && ext_req_i;
   assign sec_gnt_o = (st_q == ST_IDLE) && !ext_req_i && !pick_any && sec_req_i;
   assign me_o      = me_q;
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
   parameter int NUM_CH = 3,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        cyc_o,
   input logic [CH_W-1:0]   act_ch_o,
   input logic              ext_gnt_o,
   input logic              sec_gnt_o,
   input logic              ext_req_i,
   input logic              nmi_i,
   input logic [NUM_CH-1:0] burst_i,
   input logic [NUM_CH-1:0] xfer_en_i,
   input logic [NUM_CH-1:0] me_o
);
   assert_onehot_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cyc_o) == 1);

   assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_o[1] |=> (cyc_o[2] && $stable(act_ch_o)));

   assert_write_from_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_o[1] |=> !cyc_o[2]);

   assert_chan_change_via_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_o[2] |=> (!cyc_o[1] || $stable(act_ch_o)));

   assert_start_needs_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_o[0] |=> (!cyc_o[1] || (me_o[act_ch_o] && $past(xfer_en_i[act_ch_o]))));

   assert_ext_grant_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ext_gnt_o |-> (cyc_o[0] && ext_req_i));

   assert_ext_hold_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((cyc_o[0] || cyc_o[2]) && ext_req_i) |=> cyc_o[0]);

   assert_sec_grant_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sec_gnt_o |-> (cyc_o[0] && !ext_req_i && !ext_gnt_o));

   assert_nmi_clears_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_i |=> ((me_o & $past(burst_i)) == '0));
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cyc_o(cyc_o), .act_ch_o(act_ch_o),
   .ext_gnt_o(ext_gnt_o), .sec_gnt_o(sec_gnt_o), .ext_req_i(ext_req_i),
   .nmi_i(nmi_i), .burst_i(burst_i), .xfer_en_i(xfer_en_i), .me_o(me_o)
);

// File: tb/sim_dma_xfer_seq.sv
module sim_dma_xfer_seq;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 3;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [N-1:0]  req_i, xfer_en_i, me_set_i, burst_i;
   logic [CW-1:0] cnt_init_i;
   logic          nmi_i, ext_req_i, sec_req_i;
   logic [2:0]    cyc_o;
   logic [1:0]    act_ch_o;
   logic          ext_gnt_o, sec_gnt_o;
   logic [N-1:0]  me_o;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc_no  = 0;

   // behavioural reference state
   int m_st, m_act;
   bit m_pend[N], m_me[N], m_bact[N];
   int m_cnt[N];

   // trace of DUT read cycles
   int rd_ch[$];
   int rd_at[$];
   logic [2:0]   s_cyc;
   logic         s_ext, s_sec;
   logic [N-1:0] s_me;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_xfer_seq #(.NUM_CH(N), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .xfer_en_i(xfer_en_i),
      .me_set_i(me_set_i), .burst_i(burst_i), .cnt_init_i(cnt_init_i),
      .nmi_i(nmi_i), .ext_req_i(ext_req_i), .sec_req_i(sec_req_i),
      .cyc_o(cyc_o), .act_ch_o(act_ch_o), .ext_gnt_o(ext_gnt_o),
      .sec_gnt_o(sec_gnt_o), .me_o(me_o)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc_no);
      end
   endtask

   task automatic model_reset();
      m_st = 0; m_act = 0;
      for (int i = 0; i < N; i++) begin
         m_pend[i] = 0; m_me[i] = 0; m_bact[i] = 0; m_cnt[i] = 0;
      end
   endtask

   // one clock: compare at the falling edge, advance the model at the rising edge
   task automatic tick();
      bit menx[N], elig[N], n_pend[N], n_bact[N];
      int n_cnt[N];
      int sel, n_st, n_act, a;
      bit any, start, cont, e_ext, e_sec;
      logic [N-1:0] e_me;
      @(negedge clk);
      cyc_no++;
      any = 0; sel = 0;
      for (int i = 0; i < N; i++) begin
         menx[i] = (m_me[i] || me_set_i[i]) && !(nmi_i && burst_i[i]);
         elig[i] = (m_pend[i] || m_bact[i]) && xfer_en_i[i] && menx[i]
                   && (!burst_i[i] || m_cnt[i] != 0);
         if (elig[i] && !any) begin any = 1; sel = i; end
      end
      start = (m_st == 0) && any && !ext_req_i;
      e_ext = (m_st == 0) && ext_req_i;
      e_sec = (m_st == 0) && !ext_req_i && !any && sec_req_i;
      for (int i = 0; i < N; i++) e_me[i] = m_me[i];
      s_cyc = cyc_o; s_ext = ext_gnt_o; s_sec = sec_gnt_o; s_me = me_o;
      chk(cyc_o == 3'(1 << m_st), "R2", "cycle code", cyc_o, 1 << m_st);
      if (m_st != 0) chk(act_ch_o == 2'(m_act), "R5", "active channel", act_ch_o, m_act);
      chk(ext_gnt_o == e_ext, "R6", "external grant", ext_gnt_o, e_ext);
      chk(sec_gnt_o == e_sec, "R7", "secondary grant", sec_gnt_o, e_sec);
      chk(me_o == e_me, "R9", "master enables", me_o, e_me);
      if (cyc_o[1]) begin rd_ch.push_back(act_ch_o); rd_at.push_back(cyc_no); end
      a = m_act;
      cont = (m_st == 2) && burst_i[a] && m_bact[a] && m_cnt[a] > 1 && menx[a]
             && xfer_en_i[a] && !ext_req_i;
      for (int i = 0; i < N; i++) begin
         n_pend[i] = m_pend[i];
         if (start && sel == i) n_pend[i] = 0;
         if (req_i[i]) n_pend[i] = 1;
         n_cnt[i] = m_cnt[i];
         if (me_set_i[i]) n_cnt[i] = cnt_init_i;
         else if (m_st == 2 && a == i && burst_i[i] && m_cnt[i] != 0) n_cnt[i] = m_cnt[i] - 1;
         n_bact[i] = m_bact[i] && menx[i];
         if (start && sel == i) n_bact[i] = burst_i[i];
         else if (m_st == 2 && a == i && !cont
                  && (m_cnt[i] <= 1 || !menx[i] || !xfer_en_i[i])) n_bact[i] = 0;
      end
      n_act = start ? sel : m_act;
      case (m_st)
         0: n_st = start ? 1 : 0;
         1: n_st = 2;
         default: n_st = cont ? 1 : 0;
      endcase
      @(posedge clk);
      m_st = n_st; m_act = n_act;
      for (int i = 0; i < N; i++) begin
         m_pend[i] = n_pend[i]; m_me[i] = menx[i]; m_bact[i] = n_bact[i]; m_cnt[i] = n_cnt[i];
      end
      #1;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) tick();
   endtask

   task automatic clear_trace();
      rd_ch.delete(); rd_at.delete();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 0; req_i = '1; xfer_en_i = '0; me_set_i = '0; burst_i = '0;
      cnt_init_i = '0; nmi_i = 0; ext_req_i = 0; sec_req_i = 0;
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1; req_i = '0;

      // R1: reset state, and requests seen in reset are dropped
      sec_req_i = 1;
      ticks(2);
      chk(s_cyc == 3'b001, "R1", "idle after reset", s_cyc, 1);
      chk(s_me == 3'b000, "R1", "enables after reset", s_me, 0);
      chk(s_sec == 1'b1, "R7", "secondary grant when free", s_sec, 1);
      me_set_i = 3'b111; xfer_en_i = 3'b111; tick(); me_set_i = '0;
      ticks(5);
      chk(rd_ch.size() == 0, "R1", "no transfer from reset-time request", rd_ch.size(), 0);

      // R5, R4: simultaneous requests served 0,1,2 with an idle gap
      clear_trace();
      req_i = 3'b111; tick(); req_i = '0;
      ticks(12);
      chk(rd_ch.size() == 3, "R4", "one pair per request", rd_ch.size(), 3);
      if (rd_ch.size() == 3) begin
         for (int i = 0; i < 3; i++) chk(rd_ch[i] == i, "R5", "priority order", rd_ch[i], i);
         chk(rd_at[1] - rd_at[0] == 3, "R4", "idle between channels", rd_at[1] - rd_at[0], 3);
      end

      // R3: request held while transfer enable is low
      clear_trace();
      xfer_en_i[0] = 0; req_i[0] = 1; tick(); req_i = '0;
      ticks(4);
      chk(rd_ch.size() == 0, "R3", "no start without enable", rd_ch.size(), 0);
      xfer_en_i[0] = 1; ticks(4);
      chk(rd_ch.size() == 1, "R3", "held request served", rd_ch.size(), 1);

      // R6: external requester holds off DMA
      clear_trace();
      ext_req_i = 1; req_i[1] = 1; tick(); req_i = '0;
      ticks(3);
      chk(s_ext == 1'b1, "R6", "external grant in idle", s_ext, 1);
      chk(rd_ch.size() == 0, "R6", "DMA waits for release", rd_ch.size(), 0);
      ext_req_i = 0; ticks(4);
      chk(rd_ch.size() == 1, "R6", "DMA after release", rd_ch.size(), 1);

      // R8: burst of four back-to-back pairs
      clear_trace();
      burst_i[1] = 1; cnt_init_i = 8'd4; me_set_i[1] = 1; tick(); me_set_i = '0;
      req_i[1] = 1; tick(); req_i = '0;
      ticks(14);
      chk(rd_ch.size() == 4, "R8", "burst length", rd_ch.size(), 4);
      if (rd_ch.size() == 4)
         chk(rd_at[3] - rd_at[0] == 6, "R8", "pairs back to back", rd_at[3] - rd_at[0], 6);

      // R8: zero count keeps a burst channel parked
      clear_trace();
      req_i[1] = 1; tick(); req_i = '0;
      ticks(4);
      chk(rd_ch.size() == 0, "R8", "zero count no start", rd_ch.size(), 0);
      me_set_i[1] = 1; cnt_init_i = 8'd6; tick(); me_set_i = '0;

      // R6: burst preempted after a write and resumed
      clear_trace();
      ticks(3);
      ext_req_i = 1; ticks(4); ext_req_i = 0;
      ticks(14);
      chk(rd_ch.size() == 6, "R6", "preempted burst completes", rd_ch.size(), 6);

      // R9: NMI stops a burst, leaves non-burst enables alone
      clear_trace();
      burst_i[0] = 1; cnt_init_i = 8'd8; me_set_i[0] = 1; tick(); me_set_i = '0;
      req_i[0] = 1; tick(); req_i = '0;
      ticks(3);
      nmi_i = 1; tick(); nmi_i = 0;
      ticks(6);
      chk(s_me[0] == 1'b0, "R9", "burst enable cleared", s_me[0], 0);
      chk(s_me[2] == 1'b1, "R9", "non-burst enable kept", s_me[2], 1);
      chk(rd_ch.size() > 0 && rd_ch.size() < 8, "R9", "burst cut short", rd_ch.size(), 2);
      me_set_i[0] = 1; nmi_i = 1; tick(); me_set_i = '0; nmi_i = 0;
      tick();
      chk(s_me[0] == 1'b0, "R9", "clear wins over set", s_me[0], 0);

      // R7: secondary grant yields to external
      ext_req_i = 1; tick();
      chk(s_sec == 1'b0, "R7", "secondary blocked by external", s_sec, 0);
      ext_req_i = 0; tick();
      chk(s_sec == 1'b1, "R7", "secondary granted", s_sec, 1);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule